// File: doc/BRIEF.md
# Receiver Lock Source Controller

This controller decides whether a receive clock-recovery loop follows the incoming serial data or the local reference clock. It counts two event pulses that have already been synchronised into its own clock domain. One pulse marks each recovered word clock and the other marks each reference clock. A measurement window closes on every 2^WIN_LOG2-th recovered pulse. At that point the number of reference pulses seen in the window is compared with its nominal value, 2^WIN_LOG2. The absolute difference is the frequency offset in counts.

Two programmable thresholds give the decision hysteresis. While the loop runs on the reference, an offset strictly below `thr_enter` allows a switch to data. While the loop runs on data, the offset may grow up to `thr_exit` before the loop falls back. Lock-detect rises only after PASS_NEED consecutive passing windows measured on data. A run-length violation from an external checker overrides everything and forces reference lock on the next cycle. It also discards any measurement in progress. The status code for the status bus shows lock failure whenever lock-detect is low.

Top module: `rx_lock_ctrl`

## Requirements
- R1: During and after reset, `lock_ref` is 1, `lock_det` is 0 and `lock_stat` is 3'b101.
- R2: A high `run_fail` in a cycle makes `lock_ref`=1 and `lock_det`=0 after that clock edge, whatever the state. It clears pass progress and restarts the window. No window completes while it stays high.
- R3: In reference mode, a window whose offset |refs − 2^WIN_LOG2| is strictly below `thr_enter` switches to data mode (`lock_ref`=0, `lock_det`=0). An offset equal to or above `thr_enter` keeps reference mode.
- R4: When locked on data, a window with offset ≤ `thr_exit` keeps lock. An offset above `thr_exit` returns to reference mode.
- R5: After entering data mode, `lock_det` rises only after PASS_NEED (default 2) consecutive windows with offset ≤ `thr_exit`. Any failing window before that returns to reference mode.
- R6: `lock_stat` is 3'b000 while `lock_det` is 1 and 3'b101 while `lock_det` is 0.
- R7: A window closes on the cycle carrying the 2^WIN_LOG2-th `rec_pulse`. A `ref_pulse` in that same cycle is counted. The mode outputs change only after that edge (or after a `run_fail` edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_pulse | input | 1 | One-cycle event per recovered word clock |
| ref_pulse | input | 1 | One-cycle event per reference clock |
| run_fail | input | 1 | Run-length violation from the external checker |
| thr_enter | input | WIN_LOG2+2 | Offset limit (exclusive) for leaving reference mode |
| thr_exit | input | WIN_LOG2+2 | Offset limit (inclusive) for staying on data |
| lock_ref | output | 1 | 1 = loop follows reference, 0 = loop follows data |
| lock_det | output | 1 | Lock to data achieved |
| lock_stat | output | 3 | Status-bus code: 3'b101 lock failure, 3'b000 locked |

## Verification
The assertions assume that the pulse inputs are already single-cycle and synchronous. They also assume that `thr_enter` and `thr_exit` stay constant while a window is open, so that a decision depends only on the window just closed. The stimulus holds the thresholds fixed for the whole run. It sends recovered pulses on every other cycle, so each window is exactly 64 cycles long. The bench places the chosen number of reference pulses inside each window, which gives exact offsets on both sides of each threshold. The run-length flag changes only between windows, or stays high for a whole window.

// File: rtl/rx_lock_ctrl.sv
module rx_lock_ctrl #(
  parameter int WIN_LOG2  = 13,
  parameter int PASS_NEED = 2,
  localparam int CW = WIN_LOG2 + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_pulse,
  input  logic          ref_pulse,
  input  logic          run_fail,
  input  logic [CW-1:0] thr_enter,
  input  logic [CW-1:0] thr_exit,
  output logic          lock_ref,
  output logic          lock_det,
  output logic [2:0]    lock_stat
);
  localparam logic [CW-1:0] NOM  = CW'(1) << WIN_LOG2;
  localparam logic [CW-1:0] MAXC = '1;
  localparam int PW = $clog2(PASS_NEED + 1);

  typedef enum logic [1:0] {S_REF, S_ACQ, S_LOCK} st_t;

  st_t                 st;
  logic [WIN_LOG2-1:0] rec_cnt;
  logic [CW-1:0]       ref_cnt, ref_tot, off;
  logic [PW-1:0]       pass_cnt;
  logic                win_done, ok_enter, ok_stay;

  assign win_done = rec_pulse && (&rec_cnt);
  assign ref_tot  = (ref_cnt == MAXC) ? ref_cnt : ref_cnt + CW'(ref_pulse);
  assign off      = (ref_tot >= NOM) ? ref_tot - NOM : NOM - ref_tot;
  assign ok_enter = off < thr_enter;
  assign ok_stay  = off <= thr_exit;

  always_ff @(posedge clk) begin
    if (!rst_n || run_fail || win_done) begin
      rec_cnt <= '0;
      ref_cnt <= '0;
    end else begin
      rec_cnt <= rec_cnt + WIN_LOG2'(rec_pulse);
      ref_cnt <= ref_tot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || run_fail) begin
      st       <= S_REF;
      pass_cnt <= '0;
    end else if (win_done) begin
      case (st)
        S_REF: begin
          pass_cnt <= '0;
          if (ok_enter) st <= S_ACQ;
        end
        S_ACQ: begin
          if (!ok_stay) begin
            st       <= S_REF;
            pass_cnt <= '0;
          end else if (pass_cnt == PW'(PASS_NEED - 1)) begin
            st       <= S_LOCK;
            pass_cnt <= '0;
          end else begin
            pass_cnt <= pass_cnt + 1'b1;
          end
        end
        default: if (!ok_stay) st <= S_REF;
      endcase
    end
  end

  assign lock_ref  = (st == S_REF);
  assign lock_det  = (st == S_LOCK);
  assign lock_stat = lock_det ? 3'b000 : 3'b101;

  AST_FAIL_FORCES_REF: assert property (@(posedge clk) disable iff (!rst_n)
    run_fail |=> (lock_ref && !lock_det)); // R2
  AST_ENTER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_ref && win_done && !ok_enter) |=> lock_ref); // R3
  AST_EXIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_det && win_done && !run_fail && !ok_stay) |=> lock_ref); // R4
  AST_NO_DIRECT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_det) |-> $past(!lock_ref)); // R5
  AST_DET_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    lock_det |-> !lock_ref); // R5
  AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_done || run_fail) |=> ($stable(lock_ref) && $stable(lock_det))); // R7
endmodule

// File: tb/rx_lock_ctrl_tb.sv
`timescale 1ns/1ps
module rx_lock_ctrl_tb_top;
  localparam int WL = 5;
  localparam int CW = WL + 2;

  logic clk = 0, rst_n = 0, rec_pulse = 0, ref_pulse = 0, run_fail = 0;
  logic [CW-1:0] thr_enter = CW'(3), thr_exit = CW'(5);
  logic lock_ref, lock_det;
  logic [2:0] lock_stat;

  always #2.5 clk = ~clk;

  rx_lock_ctrl #(.WIN_LOG2(WL), .PASS_NEED(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .rec_pulse(rec_pulse), .ref_pulse(ref_pulse),
    .run_fail(run_fail), .thr_enter(thr_enter), .thr_exit(thr_exit),
    .lock_ref(lock_ref), .lock_det(lock_det), .lock_stat(lock_stat));

  typedef struct { logic r; logic d; string tag; } exp_t;
  exp_t q[$];
  event chk_ev;
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic expect_st(input logic r, input logic d, input string tag);
    exp_t e;
    e.r = r; e.d = d; e.tag = tag;
    q.push_back(e);
    -> chk_ev;
  endtask

  initial begin
    forever begin
      exp_t e;
      logic [2:0] s;
      @(chk_ev);
      e = q.pop_front();
      s = e.d ? 3'b000 : 3'b101;
      checks++;
      if (lock_ref !== e.r || lock_det !== e.d || lock_stat !== s) begin
        errors++;
        $display("FAIL %s: got ref=%b det=%b stat=%b, expected ref=%b det=%b stat=%b",
                 e.tag, lock_ref, lock_det, lock_stat, e.r, e.d, s);
      end
    end
  end

  // one window: 32 recovered pulses on odd cycles, n reference pulses
  task automatic run_window(input int n, input bit rf, input bit peek,
                            input logic pr, input logic pd);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      rec_pulse = i[0];
      ref_pulse = (i < n);
      run_fail  = rf;
      if (peek && i == 63) expect_st(pr, pd, "R7 before closing edge");
    end
    @(negedge clk);
    rec_pulse = 0; ref_pulse = 0; run_fail = 0;
  endtask

  task automatic pulse_fail();
    @(negedge clk); run_fail = 1;
    @(negedge clk); run_fail = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_st(1, 0, "R1 in reset");
    rst_n = 1;
    @(negedge clk);
    expect_st(1, 0, "R1 after reset");

    run_window(32, 0, 1, 1, 0); expect_st(0, 0, "R3 offset 0 enters data");
    run_window(33, 0, 0, 0, 0); expect_st(0, 0, "R5 one pass no detect");
    run_window(37, 0, 0, 0, 0); expect_st(0, 1, "R5 second pass at limit detects, R6");
    run_window(27, 0, 0, 0, 0); expect_st(0, 1, "R4 offset 5 keeps lock");
    run_window(38, 0, 0, 0, 0); expect_st(1, 0, "R4 offset 6 drops to reference");
    run_window(35, 0, 0, 0, 0); expect_st(1, 0, "R3 offset 3 stays on reference");
    run_window(30, 0, 0, 0, 0); expect_st(0, 0, "R3 offset 2 enters data");
    run_window(40, 0, 0, 0, 0); expect_st(1, 0, "R5 failing window in acquire");
    run_window(32, 0, 0, 0, 0); expect_st(0, 0, "R3 re-enter data");
    run_window(32, 0, 0, 0, 0); expect_st(0, 0, "R5 pass count restarted");
    run_window(32, 0, 0, 0, 0); expect_st(0, 1, "R5 lock again");
    pulse_fail();               expect_st(1, 0, "R2 run fail from lock");
    run_window(32, 1, 0, 1, 0); expect_st(1, 0, "R2 held fail blocks window");
    run_window(32, 0, 0, 0, 0); expect_st(0, 0, "R2 fresh window after fail");
    pulse_fail();               expect_st(1, 0, "R2 run fail from acquire");
    run_window(32, 0, 0, 0, 0); expect_st(0, 0, "R2 restart after acquire fail");
    run_window(64, 0, 0, 0, 0); expect_st(1, 0, "R4 fast reference in acquire");

    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule